// File: doc/BRIEF.md
# Transmit Phase-Alignment Buffer

This block passes 10-bit transmit characters from a host-side write clock into the internal character clock of one serial channel. Each character is two control bits above eight data bits. When the encoder is bypassed, the same ten bits are one pre-encoded character. The two clocks run at the same nominal frequency, so the block does no rate matching. It absorbs only their phase wander, using a small dual-clock FIFO with Gray-coded pointers and two-flop synchronisers. When the wander grows beyond what the FIFO can hold, the block raises a sticky error and sends a fixed idle character instead of data. It never applies backpressure.

The read side is a three-state machine. The states are PRIME, STREAM and FAULT.

- **PRIME:** output is idle. The machine moves to STREAM on the *primed* transition, when the synchronised fill level reaches `PRIME`.
- **STREAM:** one word is read per character clock. The machine moves to FAULT on the *slip* transition, when the synchronised fill reads zero (underflow) or `DEPTH-3` or more (overflow).
- **FAULT:** output is idle and the error is high. The *hold* transition keeps the machine in FAULT.
- **Re-centre:** from any state, a realign pulse or bypass mode takes the *recentre* transition back to PRIME. This transition reloads the read pointer from the synchronised write pointer, which re-centres the fill level.
- **Reset:** reset also enters PRIME.

When the host's input register is clocked by the full-rate reference clock, the host asserts bypass. Input words are then registered straight onto the output on the character clock, and the FIFO is not used.

Top module: `tx_phase_align`

## Requirements
- R1: During and after reset, `tx_err` is 0 and `tx_char` is the idle character. Bits [9:8] of a character are the control bits and bits [7:0] are the data bits. The idle character is 10'h1BC (control 2'b01, data 8'hBC) when `cfg_raw`=0, and 10'h0FA when `cfg_raw`=1.
- R2: With `cfg_bypass`=0 and equal clock rates, every word written on `wclk` after priming appears on `tx_char` exactly once, in write order.
- R3: After a `pa_reset` pulse, `tx_char` is idle on the next two character clocks. Data then resumes once the FIFO is primed again.
- R4: Phase wander of the write clock within half a character period either way sets no error and loses no word.
- R5: A write clock that runs persistently slower (underflow) sets `tx_err`.
- R6: A write clock that runs persistently faster (overflow) sets `tx_err`.
- R7: `tx_err` stays set after the drift stops, until `pa_reset` or bypass.
- R8: `pa_reset` clears `tx_err` on the next character clock, and lossless delivery resumes afterwards.
- R9: With `cfg_bypass`=1, `tx_char` equals `din` as sampled on the previous `rclk` edge, and `tx_err` is 0.
- R10: While `tx_err` is 1, `tx_char` is the idle character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Host transmit write clock |
| rclk | input | 1 | Internal character clock (read side) |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| cfg_bypass | input | 1 | 1: input register clocked by the full-rate reference, so the FIFO is bypassed |
| cfg_raw | input | 1 | 1: encoder bypassed, so the idle character is the 10-bit coded comma |
| pa_reset | input | 1 | Realign pulse (rclk domain): clears the error and re-centres the FIFO |
| din | input | 10 | Character from the host input register |
| tx_char | output | 10 | Character in the rclk domain |
| tx_err | output | 1 | Sticky phase-alignment error |

## Verification
A read pointer that is off by one, or a fill level that is misjudged, shows up at the ports as a dropped, repeated or reordered word. It appears within a few character clocks of priming. The scoreboard then reports a mismatch against the next word it expects.

A slip detector that is too tight raises `tx_err` during mild wander. One that is too loose never raises it under sustained drift of several character periods. A machine stuck outside FAULT loses the error as soon as the drift stops. Wrong priming lets stale FIFO contents reach `tx_char` on the very clock after a realign.

// File: rtl/txpa_pkg.sv
`timescale 1ns/10ps
package txpa_pkg;
    typedef enum logic [1:0] {
        ST_PRIME  = 2'd0,
        ST_STREAM = 2'd1,
        ST_FAULT  = 2'd2
    } pa_state_e;

    // Idle: control 2'b01 with data 8'hBC, or the 10-bit coded comma
    localparam logic [9:0] IDLE_CODED = 10'h1BC;
    localparam logic [9:0] IDLE_RAW   = 10'h0FA;
endpackage

// File: rtl/txpa_sync.sv
`timescale 1ns/10ps
module txpa_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/txpa_wrside.sv
`timescale 1ns/10ps
module txpa_wrside #(
    parameter int DW    = 10,
    parameter int DEPTH = 8
) (
    input  logic                       wclk,
    input  logic                       rst_n,
    input  logic [DW-1:0]              din,
    input  logic [$clog2(DEPTH)-1:0]   raddr,
    output logic [DW-1:0]              rdata,
    output logic [$clog2(DEPTH):0]     wgray
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [PW-1:0] wbin;
    logic [PW-1:0] wbin_n;
    logic [DW-1:0] mem [DEPTH];

    assign wbin_n = wbin + PW'(1);

    // Writer never stalls: one word per write clock
    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_n;
            wgray <= wbin_n ^ (wbin_n >> 1);
        end
    end

    always_ff @(posedge wclk) begin
        mem[wbin[AW-1:0]] <= din;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/txpa_rdctl.sv
`timescale 1ns/10ps
module txpa_rdctl
    import txpa_pkg::*;
#(
    parameter int DW    = 10,
    parameter int DEPTH = 8,
    parameter int PRIME = 2
) (
    input  logic                       rclk,
    input  logic                       rst_n,
    input  logic                       bypass,
    input  logic                       realign,
    input  logic                       raw,
    input  logic [DW-1:0]              din,
    input  logic [$clog2(DEPTH):0]     wgray_s,
    input  logic [DW-1:0]              rdata,
    output logic [$clog2(DEPTH)-1:0]   raddr,
    output logic [DW-1:0]              tx_char,
    output logic                       tx_err
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] PRIME_LVL = PW'(PRIME);
    localparam logic [PW-1:0] FULL_LVL  = PW'(DEPTH - 3);

    pa_state_e     state, state_n;
    logic [PW-1:0] rptr;
    logic [PW-1:0] wbin_s;
    logic [PW-1:0] fill;
    logic [DW-1:0] idle_w;
    logic          recentre;
    logic          keep_stream;

    always_comb begin
        for (int i = 0; i < PW; i++) begin
            wbin_s[i] = ^(wgray_s >> i);
        end
    end

    assign fill        = wbin_s - rptr;
    assign recentre    = bypass || realign;
    assign idle_w      = raw ? DW'(IDLE_RAW) : DW'(IDLE_CODED);
    assign keep_stream = (state == ST_STREAM) && (state_n == ST_STREAM);
    assign raddr       = rptr[AW-1:0];

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_PRIME:  if (fill >= PRIME_LVL) state_n = ST_STREAM;
            ST_STREAM: if (fill == '0 || fill >= FULL_LVL) state_n = ST_FAULT;
            ST_FAULT:  state_n = ST_FAULT;
            default:   state_n = ST_PRIME;
        endcase
        if (recentre) state_n = ST_PRIME;
    end

    // State register and read pointer
    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_PRIME;
            rptr  <= '0;
        end else begin
            state <= state_n;
            if (recentre)         rptr <= wbin_s;
            else if (keep_stream) rptr <= rptr + PW'(1);
        end
    end

    // Output register
    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n)           tx_char <= idle_w;
        else if (bypass)      tx_char <= din;
        else if (keep_stream) tx_char <= rdata;
        else                  tx_char <= idle_w;
    end

    assign tx_err = (state == ST_FAULT);
endmodule

// File: rtl/tx_phase_align.sv
`timescale 1ns/10ps
module tx_phase_align #(
    parameter int DW    = 10,
    parameter int DEPTH = 8,
    parameter int PRIME = 2
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          cfg_bypass,
    input  logic          cfg_raw,
    input  logic          pa_reset,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] tx_char,
    output logic          tx_err
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [PW-1:0] wgray;
    logic [PW-1:0] wgray_s;
    logic [AW-1:0] raddr;
    logic [DW-1:0] rdata;

    txpa_wrside #(.DW(DW), .DEPTH(DEPTH)) u_wr (
        .wclk  (wclk),
        .rst_n (rst_n),
        .din   (din),
        .raddr (raddr),
        .rdata (rdata),
        .wgray (wgray)
    );

    txpa_sync #(.W(PW)) u_sync (
        .clk   (rclk),
        .rst_n (rst_n),
        .d     (wgray),
        .q     (wgray_s)
    );

    txpa_rdctl #(.DW(DW), .DEPTH(DEPTH), .PRIME(PRIME)) u_rd (
        .rclk    (rclk),
        .rst_n   (rst_n),
        .bypass  (cfg_bypass),
        .realign (pa_reset),
        .raw     (cfg_raw),
        .din     (din),
        .wgray_s (wgray_s),
        .rdata   (rdata),
        .raddr   (raddr),
        .tx_char (tx_char),
        .tx_err  (tx_err)
    );
endmodule

// File: rtl/tx_phase_align_chk.sv
`timescale 1ns/10ps
module tx_phase_align_chk
    import txpa_pkg::*;
(
    input logic       rclk,
    input logic       rst_n,
    input logic       cfg_bypass,
    input logic       cfg_raw,
    input logic       pa_reset,
    input logic [9:0] din,
    input logic [9:0] tx_char,
    input logic       tx_err
);
    logic [9:0] idle_c;
    assign idle_c = cfg_raw ? IDLE_RAW : IDLE_CODED;

    AST_FAULT_IDLE: assert property (@(posedge rclk) disable iff (!rst_n)
        tx_err |-> tx_char == idle_c); // R10
    AST_FAULT_STICKY: assert property (@(posedge rclk) disable iff (!rst_n)
        tx_err && !pa_reset && !cfg_bypass |=> tx_err); // R7
    AST_REALIGN_CLEAR: assert property (@(posedge rclk) disable iff (!rst_n)
        pa_reset |=> !tx_err); // R8
    AST_REALIGN_IDLE: assert property (@(posedge rclk) disable iff (!rst_n)
        pa_reset && !cfg_bypass |=> tx_char == idle_c); // R3
    AST_BYPASS_PASS: assert property (@(posedge rclk) disable iff (!rst_n)
        cfg_bypass |=> tx_char == $past(din)); // R9
    AST_BYPASS_NOERR: assert property (@(posedge rclk) disable iff (!rst_n)
        cfg_bypass |=> !tx_err); // R9
endmodule

bind tx_phase_align tx_phase_align_chk u_chk (
    .rclk       (rclk),
    .rst_n      (rst_n),
    .cfg_bypass (cfg_bypass),
    .cfg_raw    (cfg_raw),
    .pa_reset   (pa_reset),
    .din        (din),
    .tx_char    (tx_char),
    .tx_err     (tx_err)
);

// File: tb/sim_tx_phase_align.sv
`timescale 1ns/10ps
module sim_tx_phase_align;
    logic       wclk = 1'b0;
    logic       rclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_bypass = 1'b0;
    logic       cfg_raw = 1'b0;
    logic       pa_reset = 1'b0;
    logic [9:0] din = 10'h1BC;
    logic [9:0] tx_char;
    logic       tx_err;

    realtime    whalf = 5.0;
    int         total = 0;
    int         bad = 0;
    int         seq = 0;
    bit         mon_en = 1'b0;
    bit         saw_err = 1'b0;
    logic [9:0] expq[$];
    logic [9:0] exp_w;

    tx_phase_align u0 (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .cfg_bypass(cfg_bypass),
        .cfg_raw(cfg_raw), .pa_reset(pa_reset), .din(din),
        .tx_char(tx_char), .tx_err(tx_err)
    );

    always #5 rclk = ~rclk;
    initial begin
        #2.5;
        forever #(whalf) wclk = ~wclk;
    end

    function automatic logic [9:0] idle_now();
        return cfg_raw ? 10'h0FA : 10'h1BC;
    endfunction

    function automatic logic [9:0] mkword(input int k);
        logic [9:0] v;
        v = 10'(k * 73 + 11);
        if (v == 10'h0FA || v == 10'h1BC) v = v ^ 10'h200;
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [9:0] act, input logic [9:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Driver: one word per write clock, data words go to the scoreboard
    task automatic stream(input int n, input bit data);
        for (int i = 0; i < n; i++) begin
            @(negedge wclk);
            if (data) begin
                din = mkword(seq);
                seq++;
                expq.push_back(din);
            end else begin
                din = idle_now();
            end
        end
    endtask

    task automatic drain(input string req);
        stream(30, 1'b0);
        check(expq.size() == 0, req, 10'(expq.size()), 10'd0);
        expq.delete();
    endtask

    task automatic realign();
        @(negedge rclk);
        pa_reset = 1'b1;
        @(negedge rclk);
        pa_reset = 1'b0;
        check(tx_char == idle_now(), "R3 idle after realign", tx_char, idle_now());
        check(!tx_err, "R8 error cleared", 10'(tx_err), 10'd0);
        @(negedge rclk);
        check(tx_char == idle_now(), "R3 idle second clock", tx_char, idle_now());
    endtask

    // Monitor: compare every non-idle output with the scoreboard
    always @(negedge rclk) begin
        if (tx_err) saw_err = 1'b1;
        if (mon_en && rst_n && !cfg_bypass && !tx_err && tx_char !== idle_now()) begin
            if (expq.size() == 0) begin
                check(1'b0, "R2 unexpected word", tx_char, 10'd0);
            end else begin
                exp_w = expq.pop_front();
                check(tx_char == exp_w, "R2 order", tx_char, exp_w);
            end
        end
    end

    initial begin
        #1_000_000;
        total++;
        bad++;
        $display("FAIL watchdog actual=%h expected=%h", 10'd0, 10'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (4) @(negedge rclk);
        check(!tx_err, "R1 err in reset", 10'(tx_err), 10'd0);
        check(tx_char == 10'h1BC, "R1 idle in reset", tx_char, 10'h1BC);
        rst_n = 1'b1;
        stream(20, 1'b0);
        check(!tx_err, "R1 err after reset", 10'(tx_err), 10'd0);
        check(tx_char == 10'h1BC, "R1 idle after reset", tx_char, 10'h1BC);

        // R2 steady stream
        mon_en = 1'b1;
        saw_err = 1'b0;
        stream(150, 1'b1);
        drain("R2 all delivered");
        check(!saw_err, "R2 no error", 10'(saw_err), 10'd0);

        // R4 ramped wander of about +-4 ns
        saw_err = 1'b0;
        whalf = 5.05; stream(40, 1'b1);
        whalf = 4.95; stream(80, 1'b1);
        whalf = 5.05; stream(40, 1'b1);
        whalf = 5.0;
        drain("R4 lossless under wander");
        check(!saw_err, "R4 no error under wander", 10'(saw_err), 10'd0);

        // R3 priming hold with stale data in the FIFO
        mon_en = 1'b0;
        din = 10'h155;
        repeat (20) @(negedge wclk);
        @(negedge rclk);
        check(tx_char == 10'h155, "R2 held word", tx_char, 10'h155);
        realign();
        repeat (8) @(negedge rclk);
        check(tx_char == 10'h155, "R3 resumes after priming", tx_char, 10'h155);
        din = idle_now();
        repeat (20) @(negedge wclk);
        mon_en = 1'b1;

        // R5 underflow, R7 sticky, R8 recovery
        whalf = 5.1;
        stream(300, 1'b0);
        @(negedge rclk);
        check(tx_err, "R5 underflow error", 10'(tx_err), 10'd1);
        check(tx_char == idle_now(), "R10 idle in fault", tx_char, idle_now());
        whalf = 5.0;
        stream(50, 1'b0);
        check(tx_err, "R7 error sticky", 10'(tx_err), 10'd1);
        realign();
        stream(20, 1'b0);
        saw_err = 1'b0;
        stream(100, 1'b1);
        drain("R8 lossless after realign");
        check(!saw_err, "R8 no error after realign", 10'(saw_err), 10'd0);

        // R6 overflow
        whalf = 4.9;
        stream(300, 1'b0);
        @(negedge rclk);
        check(tx_err, "R6 overflow error", 10'(tx_err), 10'd1);
        check(tx_char == idle_now(), "R10 idle in overflow fault", tx_char, idle_now());
        whalf = 5.0;
        stream(30, 1'b0);
        realign();
        stream(20, 1'b0);

        // R9 bypass
        mon_en = 1'b0;
        @(negedge rclk);
        cfg_bypass = 1'b1;
        for (int i = 0; i < 8; i++) begin
            din = mkword(500 + i);
            @(negedge rclk);
            check(tx_char == mkword(500 + i), "R9 bypass data", tx_char, mkword(500 + i));
            check(!tx_err, "R9 bypass no error", 10'(tx_err), 10'd0);
        end
        cfg_bypass = 1'b0;
        din = idle_now();
        stream(20, 1'b0);
        mon_en = 1'b1;
        stream(50, 1'b1);
        drain("R2 after bypass");

        // R1 raw idle
        mon_en = 1'b0;
        @(negedge rclk);
        rst_n = 1'b0;
        cfg_raw = 1'b1;
        din = 10'h0FA;
        repeat (3) @(negedge rclk);
        check(tx_char == 10'h0FA, "R1 raw idle in reset", tx_char, 10'h0FA);
        rst_n = 1'b1;
        stream(20, 1'b0);
        check(tx_char == 10'h0FA, "R1 raw idle after reset", tx_char, 10'h0FA);
        check(!tx_err, "R1 raw err", 10'(tx_err), 10'd0);
        mon_en = 1'b1;
        stream(40, 1'b1);
        drain("R2 raw mode delivery");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule